// File: doc/BRIEF.md
# Endpoint Configuration Register File with Base Address Registers

This block is the configuration register file of a single endpoint function. A host-side controller reaches it over a small register bus: a select strobe (the geographic device select), a read/write flag, a 3-bit function number, a 6-bit dword index into a 256-byte space, four byte enables and 32-bit write data. The block ignores every address bit above the function number and the dword index. Each accepted request gets exactly one response one clock later. The response is either an acknowledge, which carries read data for reads, or a no-response indication. The no-response indication means the addressed function does not exist.

The space opens with a standard 64-byte endpoint header. It holds the identification fields, a command register, a status word, the header-type byte, a cache line size byte, subsystem identifiers, a capabilities pointer and six base address registers (BARs). Each BAR has a fixed power-of-two size. Firmware writes all ones to a BAR and reads back a mask that encodes the size. It then writes the base address of the region it assigns. Two linked capability entries sit in the area above the header, and a status bit announces them.

Top module: `cfgspace_target`

## Requirements
- R1: After reset, the command dword (index 1) reads 0x0010_0000, the cache line dword (index 3) reads 0, every memory BAR reads 0 and the I/O BAR (BAR1, index 5) reads 0x0000_0001.
- R2: While the select strobe is low, the block gives no response and changes no state, whatever the other inputs carry.
- R3: A request with a function number other than 0 gets a no-response pulse one cycle later, carrying read data 0xFFFF_FFFF, and it writes nothing.
- R4: Index 0 reads {device 0xB7A2, vendor 0x1E5C}, index 2 reads 0x0580_0003 and index 11 reads {subsystem 0x0031, subsystem vendor 0x1E5C}. Byte 2 of index 3 (header type) reads 0. Writes to any of these fields are ignored.
- R5: Status bit 4 (bit 20 of index 1) always reads 1, and writes cannot clear it. Byte 0 of index 13 (the capabilities pointer) reads 0x40.
- R6: The capability chain has two entries. Index 16 reads {data 0x0003, next 0x48, id 0x01} and index 18 reads {data 0x0002, next 0x00, id 0x05}, so the list ends at the second entry. All other indices from 16 to 63 read 0.
- R7: Writing all ones to a BAR reads back ones above its size and zeros below it, with the type bit ORed in. The default sizes are 4 KiB memory (BAR0), 16-byte I/O (BAR1), 1 MiB memory (BAR2), not implemented (BAR3, always 0), 2 GiB memory (BAR4) and 16-byte memory (BAR5). BARs 0 to 5 sit at indices 4 to 9.
- R8: A write to a BAR keeps only the address bits at or above its size. Bit 0 always reads 1 for an I/O BAR and 0 for a memory BAR, and writes do not change it.
- R9: Command bits 0 (I/O enable), 1 (memory enable) and 2 (bus master) are writable. Command bits 15 to 3 always read 0.
- R10: Byte enable bit n qualifies write-data byte n. Bytes whose enable is 0 keep their old value.
- R11: A request sampled with the strobe high on function 0 gives a single acknowledge pulse in the next cycle. A read carries the register value and a write carries 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Request strobe (device select) |
| wr_i | input | 1 | 1 = write, 0 = read |
| fn_i | input | 3 | Function number |
| idx_i | input | 6 | Dword index into the 256-byte space |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Acknowledge, one cycle after the request |
| nores_o | output | 1 | No-response indication for absent functions |
| rdata_o | output | 32 | Read data, valid with ack_o or nores_o |

## Verification
The bench probes every BAR with all ones and checks that each size mask comes back. A BAR with the wrong size would return a mask with the boundary in the wrong bit, the unimplemented BAR would read nonzero, or the 2 GiB BAR would keep bits below bit 31. It writes to read-only fields, the capability status bit, absent functions and an idle bus, then reads the state back. A design that leaks any of those writes would show a changed ID, a cleared status bit or altered command bits. Partial byte-enable writes on a BAR and on the command register expose a design that writes whole dwords. Walking the capability chain catches a wrong next pointer or an unterminated list.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int unsigned NUM_BARS  = 6;
  localparam int unsigned BAR_BASE  = 4;   // first BAR dword index
  localparam int unsigned LOG2_W    = 5;

  typedef logic [31:0] dword_t;

  // expand byte enables to a bit mask
  function automatic dword_t be_to_mask(input logic [3:0] be);
    dword_t m;
    for (int b = 0; b < 4; b++) begin
      m[b*8 +: 8] = {8{be[b]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/cfg_bar.sv
module cfg_bar
  import cfg_pkg::*;
#(
  parameter logic [LOG2_W-1:0] SIZE_LOG2 = 5'd12,  // 0 = not implemented
  parameter logic              IS_IO     = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [3:0] be,
  input  dword_t     wdata,
  output dword_t     rdata
);

  localparam dword_t ADDR_MASK = (SIZE_LOG2 == '0) ? 32'h0 :
                                 ~((32'h1 << SIZE_LOG2) - 32'h1);
  localparam dword_t TYPE_BITS = (SIZE_LOG2 == '0) ? 32'h0 : {31'h0, IS_IO};

  dword_t base_q, base_d;
  dword_t wmask;

  always_comb begin
    wmask  = be_to_mask(be);
    base_d = ((base_q & ~wmask) | (wdata & wmask)) & ADDR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (we) begin
      base_q <= base_d;
    end
  end

  assign rdata = base_q | TYPE_BITS;

endmodule

// File: rtl/cfg_ctl_regs.sv
module cfg_ctl_regs
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       cls_we,
  input  logic [3:0] be,
  input  dword_t     wdata,
  output logic [2:0] cmd,
  output logic [7:0] cls
);

  logic [2:0] cmd_q, cmd_d;
  logic [7:0] cls_q, cls_d;
  logic       cmd_en, cls_en;

  always_comb begin
    cmd_en = cmd_we && be[0];
    cls_en = cls_we && be[0];
    cmd_d  = wdata[2:0];
    cls_d  = wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= '0;
    end else if (cls_en) begin
      cls_q <= cls_d;
    end
  end

  assign cmd = cmd_q;
  assign cls = cls_q;

endmodule

// File: rtl/cfg_cap_list.sv
module cfg_cap_list
  import cfg_pkg::*;
#(
  parameter logic [7:0]  CAP0_OFF  = 8'h40,
  parameter logic [7:0]  CAP0_ID   = 8'h01,
  parameter logic [15:0] CAP0_DATA = 16'h0003,
  parameter logic [7:0]  CAP1_OFF  = 8'h48,
  parameter logic [7:0]  CAP1_ID   = 8'h05,
  parameter logic [15:0] CAP1_DATA = 16'h0002
) (
  input  logic [5:0] idx,
  output dword_t     rdata
);

  // entry layout: {data, next pointer, id}; a zero next pointer ends the chain
  always_comb begin
    if (idx == CAP0_OFF[7:2]) begin
      rdata = {CAP0_DATA, CAP1_OFF, CAP0_ID};
    end else if (idx == CAP1_OFF[7:2]) begin
      rdata = {CAP1_DATA, 8'h00, CAP1_ID};
    end else begin
      rdata = '0;
    end
  end

endmodule

// File: rtl/cfgspace_target.sv
module cfgspace_target
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID   = 16'h1E5C,
  parameter logic [15:0] DEVICE_ID   = 16'hB7A2,
  parameter logic [31:0] CLASS_REV   = 32'h0580_0003,
  parameter logic [15:0] SUBSYS_VID  = 16'h1E5C,
  parameter logic [15:0] SUBSYS_ID   = 16'h0031,
  parameter logic [7:0]  CAP_FIRST   = 8'h40,
  parameter logic [7:0]  CAP_SECOND  = 8'h48,
  parameter logic [NUM_BARS-1:0][LOG2_W-1:0] BAR_LOG2 =
    {5'd4, 5'd31, 5'd0, 5'd20, 5'd4, 5'd12},
  parameter logic [NUM_BARS-1:0] BAR_IO = 6'b000010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_i,
  input  logic        wr_i,
  input  logic [2:0]  fn_i,
  input  logic [5:0]  idx_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic        ack_o,
  output logic        nores_o,
  output logic [31:0] rdata_o
);

  localparam logic [15:0] STATUS_VAL = 16'h0010;  // capability list present
  localparam int unsigned IDX_ID     = 0;
  localparam int unsigned IDX_CMD    = 1;
  localparam int unsigned IDX_CLASS  = 2;
  localparam int unsigned IDX_CLS    = 3;
  localparam int unsigned IDX_SUBSYS = 11;
  localparam int unsigned IDX_CAPPTR = 13;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  // request decode
  logic hit, miss, wr_hit;

  always_comb begin
    hit    = sel_i && (fn_i == 3'd0);
    miss   = sel_i && (fn_i != 3'd0);
    wr_hit = hit && wr_i;
  end

  // command and cache line size
  logic [2:0] cmd;
  logic [7:0] cls;

  cfg_ctl_regs u_ctl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd_we (wr_hit && (idx_i == 6'(IDX_CMD))),
    .cls_we (wr_hit && (idx_i == 6'(IDX_CLS))),
    .be     (be_i),
    .wdata  (wdata_i),
    .cmd    (cmd),
    .cls    (cls)
  );

  // base address registers
  dword_t bar_rd [NUM_BARS];

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    cfg_bar #(
      .SIZE_LOG2 (BAR_LOG2[g]),
      .IS_IO     (BAR_IO[g])
    ) u_bar (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (wr_hit && (idx_i == 6'(BAR_BASE + g))),
      .be    (be_i),
      .wdata (wdata_i),
      .rdata (bar_rd[g])
    );
  end

  // capability chain
  dword_t cap_rd;

  cfg_cap_list #(
    .CAP0_OFF (CAP_FIRST),
    .CAP1_OFF (CAP_SECOND)
  ) u_cap (
    .idx   (idx_i),
    .rdata (cap_rd)
  );

  // read multiplexer
  dword_t rd_mux;

  always_comb begin
    rd_mux = cap_rd;
    case (idx_i)
      6'(IDX_ID):     rd_mux = {DEVICE_ID, VENDOR_ID};
      6'(IDX_CMD):    rd_mux = {STATUS_VAL, 13'h0, cmd};
      6'(IDX_CLASS):  rd_mux = CLASS_REV;
      6'(IDX_CLS):    rd_mux = {24'h0, cls};
      6'(IDX_SUBSYS): rd_mux = {SUBSYS_ID, SUBSYS_VID};
      6'(IDX_CAPPTR): rd_mux = {24'h0, CAP_FIRST};
      default: begin
        for (int b = 0; b < NUM_BARS; b++) begin
          if (idx_i == 6'(BAR_BASE + b)) rd_mux = bar_rd[b];
        end
      end
    endcase
  end

  // response stage
  logic   ack_q, ack_d, nores_q, nores_d;
  dword_t rdata_q, rdata_d;

  always_comb begin
    ack_d   = hit;
    nores_d = miss;
    if (miss) begin
      rdata_d = '1;
    end else if (hit && !wr_i) begin
      rdata_d = rd_mux;
    end else begin
      rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_q   <= 1'b0;
      nores_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= ack_d;
      nores_q <= nores_d;
      rdata_q <= rdata_d;
    end
  end

  assign ack_o   = ack_q;
  assign nores_o = nores_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/cfgspace_chk.sv
module cfgspace_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_i,
  input logic        wr_i,
  input logic [2:0]  fn_i,
  input logic [5:0]  idx_i,
  input logic        ack_o,
  input logic        nores_o,
  input logic [31:0] rdata_o
);

  // R11: accepted request answered by one acknowledge next cycle
  p_ack_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && fn_i == 3'd0) |=> (ack_o && !nores_o));

  // R3: absent function gives no-response with all-ones data
  p_absent_fn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && fn_i != 3'd0) |=> (nores_o && !ack_o && rdata_o == 32'hFFFF_FFFF));

  // R2: idle bus gives no response
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (!ack_o && !nores_o));

  // R5: capability status bit always reads 1
  p_cap_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && fn_i == 3'd0 && idx_i == 6'd1) |=> rdata_o[20]);

  // R9: reserved command bits read 0
  p_cmd_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && fn_i == 3'd0 && idx_i == 6'd1) |=> (rdata_o[15:3] == 13'h0));

  // R4: header type byte reads 0
  p_hdr_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && fn_i == 3'd0 && idx_i == 6'd3) |=> (rdata_o[23:16] == 8'h0));

  // R11: writes carry zero data in their acknowledge
  p_wr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && fn_i == 3'd0) |=> (rdata_o == 32'h0));

endmodule

bind cfgspace_target cfgspace_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sel_i   (sel_i),
  .wr_i    (wr_i),
  .fn_i    (fn_i),
  .idx_i   (idx_i),
  .ack_o   (ack_o),
  .nores_o (nores_o),
  .rdata_o (rdata_o)
);

// File: tb/cfgspace_target_test.sv
module cfgspace_target_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_i, wr_i;
  logic [2:0]  fn_i;
  logic [5:0]  idx_i;
  logic [3:0]  be_i;
  logic [31:0] wdata_i;
  logic        ack_o, nores_o;
  logic [31:0] rdata_o;

  int compared   = 0;
  int mismatched = 0;
  bit run_done   = 0;

  typedef struct {
    bit          nores;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #2 clk = ~clk;  // 250 MHz

  cfgspace_target uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .fn_i    (fn_i),
    .idx_i   (idx_i),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .ack_o   (ack_o),
    .nores_o (nores_o),
    .rdata_o (rdata_o)
  );

  // driver: one request per call, expected response queued
  task automatic issue(input bit wr, input logic [2:0] fn, input logic [5:0] idx,
                       input logic [3:0] be, input logic [31:0] wd,
                       input bit exp_nores, input logic [31:0] exp_data,
                       input string tag);
    exp_t e;
    e.nores = exp_nores;
    e.data  = exp_data;
    e.tag   = tag;
    exp_q.push_back(e);
    @(posedge clk); #1;
    sel_i = 1'b1; wr_i = wr; fn_i = fn; idx_i = idx; be_i = be; wdata_i = wd;
    @(posedge clk); #1;
    sel_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] idx, input logic [31:0] exp, input string tag);
    issue(1'b0, 3'd0, idx, 4'h0, 32'h0, 1'b0, exp, tag);
  endtask

  task automatic wr(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d,
                    input string tag);
    issue(1'b1, 3'd0, idx, be, d, 1'b0, 32'h0, tag);
  endtask

  // monitor: compare each response with the head of the queue
  always @(negedge clk) begin
    if (rst_n && (ack_o || nores_o)) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R2/R11 unexpected response: ack=%0b nores=%0b data=%h expected none",
                 ack_o, nores_o, rdata_o);
      end else begin
        cur = exp_q.pop_front();
        if ((ack_o && nores_o) || (nores_o != cur.nores) || (rdata_o != cur.data)) begin
          mismatched++;
          $display("FAIL %s: got nores=%0b data=%h expected nores=%0b data=%h",
                   cur.tag, nores_o, rdata_o, cur.nores, cur.data);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!run_done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_i = 1'b0; wr_i = 1'b0; fn_i = '0; idx_i = '0; be_i = '0; wdata_i = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    rd(6'd1, 32'h0010_0000, "R1 command after reset");
    rd(6'd3, 32'h0000_0000, "R1 cache line after reset");
    for (int i = 0; i < 6; i++)
      rd(6'(4 + i), (i == 1) ? 32'h1 : 32'h0, "R1 BAR after reset");

    // R4 identification, read-only
    rd(6'd0,  32'hB7A2_1E5C, "R4 ids");
    rd(6'd2,  32'h0580_0003, "R4 class");
    rd(6'd11, 32'h0031_1E5C, "R4 subsystem");
    wr(6'd0,  4'hF, 32'hFFFF_FFFF, "R4 write ids");
    wr(6'd11, 4'hF, 32'h0, "R4 write subsystem");
    rd(6'd0,  32'hB7A2_1E5C, "R4 ids unchanged");
    rd(6'd11, 32'h0031_1E5C, "R4 subsystem unchanged");
    wr(6'd3,  4'hF, 32'hFFFF_FFFF, "R4 write header dword");
    rd(6'd3,  32'h0000_00FF, "R4 header type zero");

    // R5 / R6 capabilities
    rd(6'd13, 32'h0000_0040, "R5 capability pointer");
    rd(6'd16, 32'h0003_4801, "R6 first entry");
    rd(6'd18, 32'h0002_0005, "R6 last entry");
    rd(6'd17, 32'h0, "R6 gap reads zero");
    rd(6'd63, 32'h0, "R6 top reads zero");

    // R7 size probing
    for (int i = 0; i < 6; i++) wr(6'(4 + i), 4'hF, 32'hFFFF_FFFF, "R7 write ones");
    rd(6'd4, 32'hFFFF_F000, "R7 BAR0 4KiB mask");
    rd(6'd5, 32'hFFFF_FFF1, "R7 BAR1 16B io mask");
    rd(6'd6, 32'hFFF0_0000, "R7 BAR2 1MiB mask");
    rd(6'd7, 32'h0000_0000, "R7 BAR3 absent");
    rd(6'd8, 32'h8000_0000, "R7 BAR4 2GiB mask");
    rd(6'd9, 32'hFFFF_FFF0, "R7 BAR5 16B mask");

    // R8 address programming
    wr(6'd4, 4'hF, 32'h1234_5678, "R8 BAR0 program");
    wr(6'd5, 4'hF, 32'h0000_ABCC, "R8 BAR1 program");
    wr(6'd8, 4'hF, 32'hDEAD_BEEF, "R8 BAR4 program");
    rd(6'd4, 32'h1234_5000, "R8 BAR0 address");
    rd(6'd5, 32'h0000_ABC1, "R8 BAR1 io bit kept");
    rd(6'd8, 32'h8000_0000, "R8 BAR4 address");

    // R10 byte enables on a BAR
    wr(6'd6, 4'b0100, 32'h00AB_0000, "R10 BAR2 byte 2");
    rd(6'd6, 32'hFFA0_0000, "R10 BAR2 partial");

    // R9 / R10 command register
    wr(6'd1, 4'b0011, 32'hFFFF_FFFF, "R9 command ones");
    rd(6'd1, 32'h0010_0007, "R9 command enables set");
    wr(6'd1, 4'b0010, 32'h0, "R10 command upper byte only");
    rd(6'd1, 32'h0010_0007, "R10 command unchanged");
    wr(6'd1, 4'b0001, 32'h0000_0002, "R9 command memory only");
    rd(6'd1, 32'h0010_0002, "R9 command memory enable");
    wr(6'd1, 4'hF, 32'h0000_0000, "R5 try clear status");
    rd(6'd1, 32'h0010_0000, "R5 status bit stays");
    wr(6'd1, 4'h1, 32'h0000_0002, "R9 restore");

    // R3 absent function
    issue(1'b0, 3'd3, 6'd0, 4'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R3 read fn3");
    issue(1'b1, 3'd1, 6'd1, 4'hF, 32'h0, 1'b1, 32'hFFFF_FFFF, "R3 write fn1");
    issue(1'b1, 3'd7, 6'd4, 4'hF, 32'h0, 1'b1, 32'hFFFF_FFFF, "R3 write fn7 bar");
    rd(6'd1, 32'h0010_0002, "R3 command untouched");
    rd(6'd4, 32'h1234_5000, "R3 BAR untouched");

    // R2 idle bus with write-like inputs
    @(posedge clk); #1;
    wr_i = 1'b1; fn_i = 3'd0; idx_i = 6'd1; be_i = 4'hF; wdata_i = 32'h0000_0005;
    repeat (3) @(posedge clk);
    #1 wr_i = 1'b0;
    rd(6'd1, 32'h0010_0002, "R2 command unchanged by idle");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R11 missing responses: got %0d pending expected 0", exp_q.size());
    end
    run_done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule